// File: doc/BRIEF.md
# MAC Header Field Override Unit

This block sits in a wireless LAN transmit path and rewrites the control fields of an 802.11 MAC header just before the frame goes out. For each frame it takes a 64-bit setup descriptor together with the header words: frame control, duration, sequence control and QoS control. It also takes a few side inputs from neighbouring logic. These are the encapsulation type, whether the peer key implies encryption, the retry bit from the per-MPDU retry bitmap, the default sequence and fragment numbers, and the scheduler's duration.

Each covered subfield has its own preserve bit in the descriptor. A preserve bit of 1 lets the incoming value through. A preserve bit of 0 writes the value that the matching setting field selects. Some 2-bit settings choose between a constant and a value derived elsewhere: the retry bitmap, the encryption state, or a later stage's own decision. Rewriting only happens for frames marked raw or native. Every other frame leaves the block untouched.

Frames enter and leave on valid/ready streams with one registered stage between them. A frame is accepted when `in_valid` and `in_ready` are both high at a rising edge. `in_ready` is high when the stage is empty or is being emptied in the same cycle. So the block takes one frame per cycle under full throughput, and it pushes back at once when the consumer stalls.

Top module: `hov_top`

## Requirements
- R1: An accepted frame appears on the outputs one cycle later. While `out_valid` is high and `out_ready` is low, `in_ready` is low and every output holds its value. With `out_ready` held high, one frame passes per cycle.
- R2: When `in_raw_native` is 0, all four header words pass through unchanged, and the late-decision flags and `out_bad_code` stay 0, whatever the descriptor holds.
- R3: Frame control bits 7:0 always pass through. For any subfield whose preserve bit is 1, the incoming bits pass through.
- R4: The descriptor's word 0 holds the preserve bits, bits 0 to 16, in this order: to-DS, from-DS, more-frag, retry, power-mgmt, more-data, protected, order, duration, sequence control, TID, EOSP, ack policy, A-MSDU, reserved, QoS upper byte, IV. A preserve bit of 0 on a single-bit frame control subfield writes its setting bit. The single-bit subfields and their setting bits are to-DS (setting bit 17, written to FC bit 8), from-DS (18 to 9), more-frag (19 to 10), power-mgmt (22 to 12) and order (27 to 15).
- R5: Retry (setting in word-0 bits 21:20, written to FC bit 11) writes 0 for code 0 and 1 for code 1. Code 2 copies `in_retry_bit`.
- R6: More-data (setting in word-0 bits 24:23, written to FC bit 13) and EOSP (setting in word-1 bits 1:0, written to QoS bit 4) write 0 for code 0 and 1 for code 1. Code 2 writes 0 and raises `out_more_data_late` or `out_eosp_late` respectively.
- R7: Protected (setting in word-0 bits 26:25, written to FC bit 14) writes 0 for code 0 and 1 for code 1. Code 2 copies `in_key_encrypts`.
- R8: With the duration preserve bit at 0, `out_dur` equals `in_sched_dur`.
- R9: With the sequence-control preserve bit at 0, the sequence control word is written as {sequence[11:0], fragment[3:0]}. The source bit, word-1 bit 15, picks the values: 0 selects `in_def_seq` and `in_def_frag`, and 1 selects word-1 bits 31:20 and 19:16.
- R10: QoS rewrites follow the preserve bits. TID takes word-0 bits 31:28 into QoS 3:0. Ack policy takes word-1 bits 3:2 into QoS 6:5. A-MSDU takes word-1 bit 4 into QoS 7. The upper byte takes word-1 bits 12:5 into QoS 15:8.
- R11: Code 3 in an active retry, more-data, protected or EOSP setting writes 0 to that bit. It also raises `out_bad_code` with that frame's output. An inactive setting never raises it.
- R12: After reset `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input frame valid |
| in_ready | output | 1 | Block can accept a frame |
| in_desc | input | 64 | Setup descriptor, word 1 in bits 63:32 |
| in_fc | input | 16 | Incoming frame control |
| in_dur | input | 16 | Incoming duration |
| in_seq | input | 16 | Incoming sequence control |
| in_qos | input | 16 | Incoming QoS control |
| in_raw_native | input | 1 | Frame uses raw or native encapsulation |
| in_key_encrypts | input | 1 | Peer key type implies encryption |
| in_retry_bit | input | 1 | Retry bit from the retry bitmap |
| in_def_seq | input | 12 | Default sequence number |
| in_def_frag | input | 4 | Default fragment number |
| in_sched_dur | input | 16 | Duration from the scheduler |
| out_valid | output | 1 | Output frame valid |
| out_ready | input | 1 | Consumer accepts output |
| out_fc | output | 16 | Rewritten frame control |
| out_dur | output | 16 | Rewritten duration |
| out_seq | output | 16 | Rewritten sequence control |
| out_qos | output | 16 | Rewritten QoS control |
| out_more_data_late | output | 1 | More-data bit may be set later |
| out_eosp_late | output | 1 | EOSP bit may be set later |
| out_bad_code | output | 1 | Reserved setting code seen in this frame |

## Verification
The bench builds the block with its default parameters: 16-bit header words, a 12-bit sequence number and a 4-bit fragment number. With those defaults every field position named in the requirements exists, so each preserve bit and every setting code, including the reserved one, can be driven individually. At that width the default and descriptor sequence sources are also distinguishable in a single output word. Stalls are produced by holding `out_ready` low and by toggling it in an irregular pattern during a back-to-back burst.

// File: rtl/hov_pkg.sv
package hov_pkg;
  localparam int HDR_W  = 16;
  localparam int SEQ_W  = 12;
  localparam int FRAG_W = 4;
  localparam int WORD_W = 32;

  // 2-bit setting codes shared by retry, more-data, protected and EOSP
  typedef enum logic [1:0] {
    CODE_CLR = 2'd0,
    CODE_SET = 2'd1,
    CODE_ALT = 2'd2,
    CODE_BAD = 2'd3
  } code_t;

  // pick the bit a 2-bit setting selects; ALT takes the side value
  function automatic logic code_pick(input logic [1:0] code, input logic alt);
    case (code_t'(code))
      CODE_SET: code_pick = 1'b1;
      CODE_ALT: code_pick = alt;
      default:  code_pick = 1'b0;
    endcase
  endfunction

  typedef struct packed {
    logic [HDR_W-1:0] fc;
    logic [HDR_W-1:0] dur;
    logic [HDR_W-1:0] seq;
    logic [HDR_W-1:0] qos;
    logic             md_late;
    logic             eosp_late;
    logic             bad;
  } hov_frame_t;
endpackage

// File: rtl/hov_fc_unit.sv
module hov_fc_unit
  import hov_pkg::*;
#(
  parameter int HW = HDR_W,
  parameter int WW = WORD_W
) (
  input  logic [HW-1:0] fc_in,
  input  logic [WW-1:0] w0,
  input  logic          active,
  input  logic          key_enc,
  input  logic          retry_bit,
  output logic [HW-1:0] fc_out,
  output logic          md_late,
  output logic          bad
);
  localparam int NSB = 5;
  localparam int SB_MASK [NSB] = '{0, 1, 2, 4, 7};
  localparam int SB_SET  [NSB] = '{17, 18, 19, 22, 27};
  localparam int SB_FC   [NSB] = '{8, 9, 10, 12, 15};

  logic [NSB-1:0] sb_en, sb_val;

  for (genvar g = 0; g < NSB; g++) begin : g_single
    assign sb_en[g]  = active && !w0[SB_MASK[g]];
    assign sb_val[g] = w0[SB_SET[g]];
  end

  logic       rt_en, md_en, pr_en;
  logic [1:0] rt_code, md_code, pr_code;

  assign rt_en   = active && !w0[3];
  assign md_en   = active && !w0[5];
  assign pr_en   = active && !w0[6];
  assign rt_code = w0[21:20];
  assign md_code = w0[24:23];
  assign pr_code = w0[26:25];

  always_comb begin
    fc_out = fc_in;
    for (int i = 0; i < NSB; i++)
      if (sb_en[i]) fc_out[SB_FC[i]] = sb_val[i];
    if (rt_en) fc_out[11] = code_pick(rt_code, retry_bit);
    if (md_en) fc_out[13] = code_pick(md_code, 1'b0);
    if (pr_en) fc_out[14] = code_pick(pr_code, key_enc);
  end

  assign md_late = md_en && (md_code == CODE_ALT);
  assign bad = (rt_en && rt_code == CODE_BAD) ||
               (md_en && md_code == CODE_BAD) ||
               (pr_en && pr_code == CODE_BAD);
endmodule

// File: rtl/hov_qos_unit.sv
module hov_qos_unit
  import hov_pkg::*;
#(
  parameter int HW = HDR_W,
  parameter int WW = WORD_W
) (
  input  logic [HW-1:0] qos_in,
  input  logic [WW-1:0] w0,
  input  logic [WW-1:0] w1,
  input  logic          active,
  output logic [HW-1:0] qos_out,
  output logic          eosp_late,
  output logic          bad
);
  localparam int UB_W = HW - 8;

  logic       tid_en, eo_en, ack_en, am_en, ub_en;
  logic [1:0] eo_code;

  assign tid_en  = active && !w0[10];
  assign eo_en   = active && !w0[11];
  assign ack_en  = active && !w0[12];
  assign am_en   = active && !w0[13];
  assign ub_en   = active && !w0[15];
  assign eo_code = w1[1:0];

  always_comb begin
    qos_out = qos_in;
    if (tid_en) qos_out[3:0]     = w0[31:28];
    if (eo_en)  qos_out[4]       = code_pick(eo_code, 1'b0);
    if (ack_en) qos_out[6:5]     = w1[3:2];
    if (am_en)  qos_out[7]       = w1[4];
    if (ub_en)  qos_out[HW-1:8]  = w1[5 +: UB_W];
  end

  assign eosp_late = eo_en && (eo_code == CODE_ALT);
  assign bad       = eo_en && (eo_code == CODE_BAD);
endmodule

// File: rtl/hov_seq_unit.sv
module hov_seq_unit
  import hov_pkg::*;
#(
  parameter int HW = HDR_W,
  parameter int WW = WORD_W,
  parameter int SW = SEQ_W,
  parameter int FW = FRAG_W
) (
  input  logic [HW-1:0] seq_in,
  input  logic [HW-1:0] dur_in,
  input  logic [HW-1:0] sched_dur,
  input  logic [SW-1:0] def_seq,
  input  logic [FW-1:0] def_frag,
  input  logic [WW-1:0] w0,
  input  logic [WW-1:0] w1,
  input  logic          active,
  output logic [HW-1:0] seq_out,
  output logic [HW-1:0] dur_out
);
  localparam int FRAG_LSB = 16;
  localparam int SEQ_LSB  = FRAG_LSB + FW;

  logic [SW-1:0] sel_seq;
  logic [FW-1:0] sel_frag;

  assign sel_seq  = w1[15] ? w1[SEQ_LSB +: SW]  : def_seq;
  assign sel_frag = w1[15] ? w1[FRAG_LSB +: FW] : def_frag;

  assign seq_out = (active && !w0[9]) ? {sel_seq, sel_frag} : seq_in;
  assign dur_out = (active && !w0[8]) ? sched_dur : dur_in;
endmodule

// File: rtl/hov_top.sv
module hov_top
  import hov_pkg::*;
#(
  parameter int HW = HDR_W,
  parameter int SW = SEQ_W,
  parameter int FW = FRAG_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [2*WORD_W-1:0] in_desc,
  input  logic [HW-1:0]   in_fc,
  input  logic [HW-1:0]   in_dur,
  input  logic [HW-1:0]   in_seq,
  input  logic [HW-1:0]   in_qos,
  input  logic            in_raw_native,
  input  logic            in_key_encrypts,
  input  logic            in_retry_bit,
  input  logic [SW-1:0]   in_def_seq,
  input  logic [FW-1:0]   in_def_frag,
  input  logic [HW-1:0]   in_sched_dur,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [HW-1:0]   out_fc,
  output logic [HW-1:0]   out_dur,
  output logic [HW-1:0]   out_seq,
  output logic [HW-1:0]   out_qos,
  output logic            out_more_data_late,
  output logic            out_eosp_late,
  output logic            out_bad_code
);
  localparam int WW = WORD_W;

  logic [WW-1:0] w0, w1;
  logic          fc_bad, qos_bad, load;
  hov_frame_t    nxt, held;
  logic          vld_q;

  assign w0 = in_desc[WW-1:0];
  assign w1 = in_desc[2*WW-1:WW];

  hov_fc_unit #(.HW(HW), .WW(WW)) u_fc (
    .fc_in(in_fc), .w0(w0), .active(in_raw_native),
    .key_enc(in_key_encrypts), .retry_bit(in_retry_bit),
    .fc_out(nxt.fc), .md_late(nxt.md_late), .bad(fc_bad)
  );

  hov_qos_unit #(.HW(HW), .WW(WW)) u_qos (
    .qos_in(in_qos), .w0(w0), .w1(w1), .active(in_raw_native),
    .qos_out(nxt.qos), .eosp_late(nxt.eosp_late), .bad(qos_bad)
  );

  hov_seq_unit #(.HW(HW), .WW(WW), .SW(SW), .FW(FW)) u_seq (
    .seq_in(in_seq), .dur_in(in_dur), .sched_dur(in_sched_dur),
    .def_seq(in_def_seq), .def_frag(in_def_frag),
    .w0(w0), .w1(w1), .active(in_raw_native),
    .seq_out(nxt.seq), .dur_out(nxt.dur)
  );

  assign nxt.bad = fc_bad || qos_bad;

  // single output slot: refill when empty or draining this cycle
  assign in_ready = !vld_q || out_ready;
  assign load     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      held  <= '0;
    end else begin
      if (load)           vld_q <= 1'b1;
      else if (out_ready) vld_q <= 1'b0;
      if (load)           held  <= nxt;
    end
  end

  assign out_valid          = vld_q;
  assign out_fc             = held.fc;
  assign out_dur            = held.dur;
  assign out_seq            = held.seq;
  assign out_qos            = held.qos;
  assign out_more_data_late = vld_q && held.md_late;
  assign out_eosp_late      = vld_q && held.eosp_late;
  assign out_bad_code       = vld_q && held.bad;
endmodule

// File: rtl/hov_chk.sv
module hov_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [15:0] in_fc,
  input logic [15:0] in_dur,
  input logic [15:0] in_seq,
  input logic [15:0] in_qos,
  input logic        in_raw_native,
  input logic        out_valid,
  input logic        out_ready,
  input logic [15:0] out_fc,
  input logic [15:0] out_dur,
  input logic [15:0] out_seq,
  input logic [15:0] out_qos,
  input logic        out_more_data_late,
  input logic        out_eosp_late,
  input logic        out_bad_code
);
  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_fc) && $stable(out_dur)
                                && $stable(out_seq) && $stable(out_qos));

  assert_backpressure_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  assert_bypass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !in_raw_native |=>
      out_fc == $past(in_fc) && out_dur == $past(in_dur) &&
      out_seq == $past(in_seq) && out_qos == $past(in_qos) &&
      !out_more_data_late && !out_eosp_late && !out_bad_code);

  assert_lowbyte_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_fc[7:0] == $past(in_fc[7:0]));

  assert_md_late_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_more_data_late |-> out_valid && !out_fc[13]);

  assert_eosp_late_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_eosp_late |-> out_valid && !out_qos[4]);

  assert_bad_framed_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_bad_code |-> out_valid);
endmodule

bind hov_top hov_chk u_hov_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_fc(in_fc), .in_dur(in_dur), .in_seq(in_seq), .in_qos(in_qos),
  .in_raw_native(in_raw_native), .out_valid(out_valid), .out_ready(out_ready),
  .out_fc(out_fc), .out_dur(out_dur), .out_seq(out_seq), .out_qos(out_qos),
  .out_more_data_late(out_more_data_late), .out_eosp_late(out_eosp_late),
  .out_bad_code(out_bad_code)
);

// File: tb/sim_hov_top.sv
module sim_hov_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam logic [63:0] KEEP_ALL = 64'h0000_0000_0001_BFFF;
  localparam logic [15:0] FC0  = 16'h5A3C;
  localparam logic [15:0] QOS0 = 16'hC3A5;
  localparam logic [15:0] DUR0 = 16'h1234;
  localparam logic [15:0] SEQ0 = 16'hABCD;
  localparam logic [15:0] SDUR = 16'h0F0E;
  localparam logic [11:0] DSEQ = 12'h765;
  localparam logic [3:0]  DFRG = 4'h9;

  typedef struct {
    logic [15:0] fc, dur, seq, qos;
    logic mdl, eol, bad;
    string tag;
  } item_t;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready;
  logic [63:0] in_desc = '0;
  logic [15:0] in_fc = '0, in_dur = '0, in_seq = '0, in_qos = '0, in_sched_dur = '0;
  logic in_raw_native = 0, in_key_encrypts = 0, in_retry_bit = 0;
  logic [11:0] in_def_seq = '0;
  logic [3:0]  in_def_frag = '0;
  logic out_valid, out_ready = 1;
  logic [15:0] out_fc, out_dur, out_seq, out_qos;
  logic out_more_data_late, out_eosp_late, out_bad_code;

  int checks = 0, errors = 0;
  int ready_mode = 0;
  bit finished = 0;
  item_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  hov_top u0 (.*);

  function automatic item_t model(input logic [63:0] d, input logic [15:0] fc, dur, seq, qos,
                                  input logic raw, key, rb);
    item_t r;
    r.fc = fc; r.dur = dur; r.seq = seq; r.qos = qos;
    r.mdl = 0; r.eol = 0; r.bad = 0;
    if (raw) begin
      if (!d[0]) r.fc[8]  = d[17];
      if (!d[1]) r.fc[9]  = d[18];
      if (!d[2]) r.fc[10] = d[19];
      if (!d[3]) begin
        r.fc[11] = (d[21:20] == 1) || (d[21:20] == 2 && rb);
        if (d[21:20] == 3) r.bad = 1;
      end
      if (!d[4]) r.fc[12] = d[22];
      if (!d[5]) begin
        r.fc[13] = (d[24:23] == 1);
        r.mdl = (d[24:23] == 2);
        if (d[24:23] == 3) r.bad = 1;
      end
      if (!d[6]) begin
        r.fc[14] = (d[26:25] == 1) || (d[26:25] == 2 && key);
        if (d[26:25] == 3) r.bad = 1;
      end
      if (!d[7]) r.fc[15] = d[27];
      if (!d[8]) r.dur = SDUR;
      if (!d[9]) r.seq = d[47] ? {d[63:52], d[51:48]} : {DSEQ, DFRG};
      if (!d[10]) r.qos[3:0] = d[31:28];
      if (!d[11]) begin
        r.qos[4] = (d[33:32] == 1);
        r.eol = (d[33:32] == 2);
        if (d[33:32] == 3) r.bad = 1;
      end
      if (!d[12]) r.qos[6:5]  = d[35:34];
      if (!d[13]) r.qos[7]    = d[36];
      if (!d[15]) r.qos[15:8] = d[44:37];
    end
    return r;
  endfunction

  task automatic send(input string tag, input logic [63:0] d, input logic raw,
                      input logic key, input logic rb,
                      input logic [15:0] fc = FC0, input logic [15:0] qos = QOS0);
    item_t e;
    @(negedge clk);
    in_valid = 1; in_desc = d; in_fc = fc; in_dur = DUR0; in_seq = SEQ0; in_qos = qos;
    in_raw_native = raw; in_key_encrypts = key; in_retry_bit = rb;
    in_def_seq = DSEQ; in_def_frag = DFRG; in_sched_dur = SDUR;
    #1;
    while (!in_ready) begin
      @(negedge clk); #1;
    end
    e = model(d, fc, DUR0, SEQ0, qos, raw, key, rb);
    e.tag = tag;
    sb.push_back(e);
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic check1(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // out_ready driver
  int rcnt = 0;
  always @(negedge clk) begin
    rcnt++;
    case (ready_mode)
      0: out_ready <= 1;
      1: out_ready <= ((rcnt * 7) % 5) > 1;
      default: out_ready <= 0;
    endcase
  end

  // monitor
  always @(negedge clk) begin
    #2;
    if (rst_n && out_valid && out_ready) begin
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL R1: unexpected output fc %h", out_fc);
      end else begin
        item_t e;
        e = sb.pop_front();
        if (out_fc !== e.fc || out_dur !== e.dur || out_seq !== e.seq || out_qos !== e.qos ||
            out_more_data_late !== e.mdl || out_eosp_late !== e.eol || out_bad_code !== e.bad) begin
          errors++;
          $display("FAIL %s: actual fc=%h dur=%h seq=%h qos=%h md=%b eo=%b bad=%b expected fc=%h dur=%h seq=%h qos=%h md=%b eo=%b bad=%b",
                   e.tag, out_fc, out_dur, out_seq, out_qos, out_more_data_late, out_eosp_late, out_bad_code,
                   e.fc, e.dur, e.seq, e.qos, e.mdl, e.eol, e.bad);
        end
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [63:0] d;
    repeat (3) @(posedge clk);
    #1;
    check1("R12 out_valid", {63'b0, out_valid}, 64'd0);
    check1("R12 in_ready", {63'b0, in_ready}, 64'd1);
    @(negedge clk); rst_n = 1;

    // R2: non-raw ignores an all-override descriptor
    send("R2", 64'hFFFF_E000_FFFE_4000, 0, 1, 1);
    // R3: raw with every preserve bit set
    send("R3", KEEP_ALL | 64'h0000_1FFF_FFFE_0000, 1, 1, 1);
    // R4: single-bit FC settings, two patterns
    d = KEEP_ALL & ~64'h9F; d[17] = 1; d[18] = 0; d[19] = 1; d[22] = 0; d[27] = 1;
    send("R4 pattern A", d, 1, 0, 0, 16'h0000);
    d = KEEP_ALL & ~64'h97; d[17] = 0; d[18] = 1; d[19] = 0; d[22] = 1; d[27] = 0;
    send("R4 pattern B", d, 1, 0, 0, 16'hFFFF);
    // R5: retry codes
    for (int c = 0; c < 3; c++) begin
      d = KEEP_ALL & ~64'h8; d[21:20] = c[1:0];
      send("R5 retry", d, 1, 0, 1, c == 1 ? 16'h0000 : 16'h0800);
      send("R5 retry", d, 1, 0, 0, 16'h0800);
    end
    // R6: more-data and EOSP late codes
    d = KEEP_ALL & ~64'h820; d[24:23] = 2; d[33:32] = 2;
    send("R6 late", d, 1, 0, 0, 16'h2000, 16'h0010);
    d = KEEP_ALL & ~64'h820; d[24:23] = 1; d[33:32] = 1;
    send("R6 set", d, 1, 0, 0, 16'h0000, 16'h0000);
    // R7: protected derived from key
    d = KEEP_ALL & ~64'h40; d[26:25] = 2;
    send("R7 key on", d, 1, 1, 0, 16'h0000);
    send("R7 key off", d, 1, 0, 0, 16'h4000);
    // R8: duration
    send("R8 duration", KEEP_ALL & ~64'h100, 1, 0, 0);
    // R9: sequence source
    d = KEEP_ALL & ~64'h200; d[47] = 0; d[63:48] = 16'h3C5A;
    send("R9 default src", d, 1, 0, 0);
    d[47] = 1;
    send("R9 desc src", d, 1, 0, 0);
    send("R9 preserve", d | 64'h200, 1, 0, 0);
    // R10: QoS fields
    d = KEEP_ALL & ~64'hB400; d[31:28] = 4'h6; d[35:34] = 2'b10; d[36] = 0; d[44:37] = 8'h3E;
    send("R10 qos", d, 1, 0, 0);
    // R11: reserved codes, active and inactive
    d = KEEP_ALL & ~64'h8; d[21:20] = 3;
    send("R11 retry bad", d, 1, 0, 1, 16'h0800);
    d = KEEP_ALL & ~64'h800; d[33:32] = 3;
    send("R11 eosp bad", d, 1, 0, 0, FC0, 16'h0010);
    d = KEEP_ALL; d[26:25] = 3;
    send("R11 inactive", d, 1, 0, 0);

    // R1: stall holds the output and blocks input
    idle();
    repeat (3) @(posedge clk);
    ready_mode = 2;
    repeat (2) @(posedge clk);
    send("R1 stalled item", KEEP_ALL & ~64'h100, 1, 0, 0);
    idle();
    repeat (3) @(negedge clk);
    #1;
    check1("R1 in_ready low", {63'b0, in_ready}, 64'd0);
    check1("R1 held dur", {48'b0, out_dur}, {48'b0, SDUR});
    ready_mode = 0;

    // R1: burst with irregular back-pressure
    ready_mode = 1;
    for (int k = 0; k < 24; k++) begin
      d = KEEP_ALL & ~(64'h1 << (k % 14));
      d[63:17] = {47{k[0]}} ^ 47'h2A5A_5A5A_5A5A;
      d[14] = 0;
      send("R1 burst", d, k % 3 != 0, k[1], k[2], FC0 ^ 16'(k));
    end
    idle();
    ready_mode = 0;
    repeat (20) @(posedge clk);
    check1("R1 scoreboard drained", 64'(sb.size()), 64'd0);
    finish_run();
  end
endmodule